// File: doc/BRIEF.md
# Dual-CPU Boot Release Controller

This block is a small register file that decides when each of up to two processor cores may leave its post-reset hold. Software writes a hold register: a core whose hold bit changes from 1 to 0 gets a one-cycle power-on-and-reset request. Writing a 1 into a hold bit only changes the stored value. The block never takes a running core down.

Each core also has a boot vector register. It gives the base of the secure vector table that the core samples when it next leaves reset, so a new value takes effect only at that core's next reset.

A parameter selects a dual-core or a single-core build. In the single-core build the second core's vector register does not exist. A fixed set of read-only identification bytes is also present.

The register port accepts one access in every cycle where `bus_valid` is high, so there is no back-pressure. Each accepted access gets exactly one response on the next cycle (`rsp_valid`), with read data and an error flag.

Top module: `boot_release_ctl`

## Requirements
- R1: After reset the hold register reads `WAIT_RST` (default 2) in the dual-core build and 0 in the single-core build. Both vector registers read 0x1000_0000.
- R2: A write to offset 0x010 that finds hold bit i at 1 and carries 0 in bit i drives `cpu_release[i]` high for exactly the one cycle after the write.
- R3: A write to offset 0x010 that leaves a hold bit at 0, or that sets it from 0 to 1, produces no release pulse for that core. `cpu_wait` follows the stored bit, and no other output acts on a running core.
- R4: One write that clears both hold bits releases both cores in the same cycle.
- R5: Offset 0x010 reads back all 32 bits of the last value written, including bits above the per-core hold bits. `cpu_wait[i]` equals stored bit i for each present core.
- R6: A write to offset 0x014 (core 0) or 0x018 (core 1) updates the matching `boot_vec` output on the next cycle and reads back unchanged.
- R7: Offsets 0xFF0, 0xFF4, 0xFF8 and 0xFFC read as 0x0D, 0xF0, 0x05 and 0xB1.
- R8: An access to any other offset, including an offset that is not word aligned, responds with `rsp_err` high and `rsp_rdata` zero, and a write to it changes no register.
- R9: In the single-core build, offset 0x018 is an invalid offset as in R8, `boot_vec1` stays 0, and `cpu_release[1]` and `cpu_wait[1]` stay 0.
- R10: Every accepted access gets `rsp_valid` high on the next cycle. `rsp_err` is high only together with `rsp_valid`. A write responds with zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request, accepted every cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_rdata | output | 32 | Read data, zero for writes and for errors |
| rsp_err | output | 1 | Access hit an absent or invalid offset |
| cpu_wait | output | 2 | Per-core hold level |
| cpu_release | output | 2 | Per-core single-cycle power-on-and-reset request |
| boot_vec0 | output | 32 | Vector table base for core 0 |
| boot_vec1 | output | 32 | Vector table base for core 1 (0 in single-core build) |

## Verification
The hold logic is driven through every pair of old and new two-bit hold values. This tells apart:
- a true 1-to-0 clear, which must release the core;
- a 0-to-1 set, which must stay silent;
- an unchanged bit, which must also stay silent;
- a double clear, which must release both cores at once.

Every word offset of the 4 KiB window is read on a dual-core and a single-core copy at the same time. This separates the valid, absent and identification offsets, so a decode slip shows as a wrong error flag or wrong data. Writes of all ones to every invalid offset, followed by readback, show whether an ignored write leaks into a register.

// File: rtl/boot_release_pkg.sv
package boot_release_pkg;

  localparam int OFF_WAIT = 'h010;
  localparam int OFF_VEC0 = 'h014;
  localparam int OFF_VEC1 = 'h018;
  localparam int OFF_ID0  = 'hFF0;
  localparam int ID_COUNT = 4;
  localparam int DATA_W   = 32;
  localparam int MAX_CPU  = 2;

  typedef struct packed {
    logic       hit_wait;
    logic       hit_vec0;
    logic       hit_vec1;
    logic       hit_id;
    logic [1:0] id_idx;
  } dec_t;

  function automatic logic [7:0] id_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h0D;
      2'd1:    return 8'hF0;
      2'd2:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/boot_addr_decode.sv
module boot_addr_decode
  import boot_release_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter bit DUAL_CORE = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] A_WAIT = ADDR_W'(OFF_WAIT);
  localparam logic [ADDR_W-1:0] A_VEC0 = ADDR_W'(OFF_VEC0);
  localparam logic [ADDR_W-1:0] A_VEC1 = ADDR_W'(OFF_VEC1);
  localparam logic [ADDR_W-1:0] A_ID0  = ADDR_W'(OFF_ID0);
  localparam logic [ADDR_W-1:0] A_IDN  = ADDR_W'(OFF_ID0 + 4 * (ID_COUNT - 1));

  always_comb begin
    dec          = '0;
    dec.hit_wait = (addr == A_WAIT);
    dec.hit_vec0 = (addr == A_VEC0);
    dec.hit_vec1 = DUAL_CORE && (addr == A_VEC1);
    dec.hit_id   = (addr >= A_ID0) && (addr <= A_IDN) && (addr[1:0] == 2'b00);
    dec.id_idx   = addr[3:2];
    hit          = dec.hit_wait | dec.hit_vec0 | dec.hit_vec1 | dec.hit_id;
  end
endmodule

// File: rtl/boot_wait_reg.sv
module boot_wait_reg
  import boot_release_pkg::*;
#(
  parameter int              NCPU     = 2,
  parameter logic [DATA_W-1:0] WAIT_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] wait_q,
  output logic [MAX_CPU-1:0] hold,
  output logic [MAX_CPU-1:0] release_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  wait_q <= WAIT_RST;
    else if (we) wait_q <= wdata;
  end

  for (genvar i = 0; i < MAX_CPU; i++) begin : g_cpu
    if (i < NCPU) begin : g_present
      logic rel_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rel_q <= 1'b0;
        else        rel_q <= we && wait_q[i] && !wdata[i];
      end
      assign release_o[i] = rel_q;
      assign hold[i]      = wait_q[i];
    end else begin : g_absent
      assign release_o[i] = 1'b0;
      assign hold[i]      = 1'b0;
    end
  end
endmodule

// File: rtl/boot_vec_reg.sv
module boot_vec_reg
  import boot_release_pkg::*;
#(
  parameter logic [DATA_W-1:0] VEC_RST = 32'h1000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] vec_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  vec_q <= VEC_RST;
    else if (we) vec_q <= wdata;
  end
endmodule

// File: rtl/boot_release_ctl.sv
module boot_release_ctl
  import boot_release_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter bit          DUAL_CORE = 1'b1,
  parameter logic [31:0] WAIT_RST  = 32'h0000_0002,
  parameter logic [31:0] VEC_RST   = 32'h1000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic [1:0]        cpu_wait,
  output logic [1:0]        cpu_release,
  output logic [31:0]       boot_vec0,
  output logic [31:0]       boot_vec1
);
  localparam int          NCPU       = DUAL_CORE ? 2 : 1;
  localparam logic [31:0] WAIT_RESET = DUAL_CORE ? WAIT_RST : 32'h0;

  dec_t        dec;
  logic        hit;
  logic        wr;
  logic [31:0] wait_q;
  logic [31:0] rd_mux;

  assign wr = bus_valid && bus_write;

  boot_addr_decode #(.ADDR_W(ADDR_W), .DUAL_CORE(DUAL_CORE)) u_dec (
    .addr (bus_addr),
    .dec  (dec),
    .hit  (hit)
  );

  boot_wait_reg #(.NCPU(NCPU), .WAIT_RST(WAIT_RESET)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (wr && dec.hit_wait),
    .wdata     (bus_wdata),
    .wait_q    (wait_q),
    .hold      (cpu_wait),
    .release_o (cpu_release)
  );

  boot_vec_reg #(.VEC_RST(VEC_RST)) u_vec0 (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr && dec.hit_vec0),
    .wdata (bus_wdata),
    .vec_q (boot_vec0)
  );

  if (DUAL_CORE) begin : g_vec1
    boot_vec_reg #(.VEC_RST(VEC_RST)) u_vec1 (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr && dec.hit_vec1),
      .wdata (bus_wdata),
      .vec_q (boot_vec1)
    );
  end else begin : g_no_vec1
    assign boot_vec1 = '0;
  end

  always_comb begin
    rd_mux = '0;
    if (dec.hit_wait)      rd_mux = wait_q;
    else if (dec.hit_vec0) rd_mux = boot_vec0;
    else if (dec.hit_vec1) rd_mux = boot_vec1;
    else if (dec.hit_id)   rd_mux = {24'h0, id_byte(dec.id_idx)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_valid;
      rsp_err   <= bus_valid && !hit;
      rsp_rdata <= (bus_valid && !bus_write && hit) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/boot_release_chk.sv
module boot_release_chk
  import boot_release_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic [1:0]        cpu_wait,
  input logic [1:0]        cpu_release,
  input logic [31:0]       boot_vec0
);
  logic wr_wait;
  assign wr_wait = bus_valid && bus_write && (bus_addr == ADDR_W'(OFF_WAIT));

  a_r2_release_cpu0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wait && cpu_wait[0] && !bus_wdata[0]) |=> cpu_release[0]);
  a_r4_release_cpu1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wait && cpu_wait[1] && !bus_wdata[1]) |=> cpu_release[1]);
  a_r3_no_spurious_release0: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_release[0] |-> $past(wr_wait && cpu_wait[0] && !bus_wdata[0]));
  a_r3_no_spurious_release1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_release[1] |-> $past(wr_wait && cpu_wait[1] && !bus_wdata[1]));
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_release[0] |=> !cpu_release[0]);
  a_r10_response: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> rsp_valid);
  a_r10_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  a_r8_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 32'h0));
  a_r6_vec_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write) |=> $stable(boot_vec0));
endmodule

bind boot_release_ctl boot_release_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .rsp_err     (rsp_err),
  .cpu_wait    (cpu_wait),
  .cpu_release (cpu_release),
  .boot_vec0   (boot_vec0)
);

// File: tb/test_boot_release_ctl.sv
module test_boot_release_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;

  logic        d_rv, d_re, s_rv, s_re;
  logic [31:0] d_rd, s_rd, d_v0, d_v1, s_v0, s_v1;
  logic [1:0]  d_w, d_rel, s_w, s_rel;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  localparam logic [11:0] A_WAIT = 12'h010;
  localparam logic [11:0] A_V0   = 12'h014;
  localparam logic [11:0] A_V1   = 12'h018;

  logic [31:0] m_wait_d = 32'h2, m_wait_s = 32'h0;
  logic [31:0] m_v0_d = 32'h1000_0000, m_v0_s = 32'h1000_0000, m_v1_d = 32'h1000_0000;

  always #10 clk = ~clk;

  boot_release_ctl #(.DUAL_CORE(1'b1)) i_boot_release_ctl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(d_rv), .rsp_rdata(d_rd),
    .rsp_err(d_re), .cpu_wait(d_w), .cpu_release(d_rel), .boot_vec0(d_v0), .boot_vec1(d_v1));

  boot_release_ctl #(.DUAL_CORE(1'b0)) i_boot_release_ctl_sc (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(s_rv), .rsp_rdata(s_rd),
    .rsp_err(s_re), .cpu_wait(s_w), .cpu_release(s_rel), .boot_vec0(s_v0), .boot_vec1(s_v1));

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_id(input logic [11:0] a);
    return (a >= 12'hFF0) && (a[1:0] == 2'b00);
  endfunction

  function automatic bit hit(input bit dual, input logic [11:0] a);
    return (a == A_WAIT) || (a == A_V0) || (dual && a == A_V1) || is_id(a);
  endfunction

  function automatic logic [31:0] model_rd(input bit dual, input logic [11:0] a);
    if (a == A_WAIT) return dual ? m_wait_d : m_wait_s;
    if (a == A_V0)   return dual ? m_v0_d : m_v0_s;
    if (a == A_V1)   return dual ? m_v1_d : 32'h0;
    if (is_id(a)) begin
      case (a[3:2])
        2'd0:    return 32'h0D;
        2'd1:    return 32'hF0;
        2'd2:    return 32'h05;
        default: return 32'hB1;
      endcase
    end
    return 32'h0;
  endfunction

  function automatic string tag_of(input bit dual, input logic [11:0] a);
    if (a == A_WAIT) return "R5";
    if (a == A_V0) return "R6";
    if (a == A_V1) return dual ? "R6" : "R9";
    if (is_id(a)) return "R7";
    return "R8";
  endfunction

  task automatic do_acc(input bit w, input logic [11:0] a, input logic [31:0] d);
    logic [31:0] er_d, er_s;
    logic [1:0]  xr_d, xr_s;
    bit eh_d, eh_s;
    eh_d = hit(1'b1, a);
    eh_s = hit(1'b0, a);
    er_d = w ? 32'h0 : model_rd(1'b1, a);
    er_s = w ? 32'h0 : model_rd(1'b0, a);
    xr_d = (w && a == A_WAIT) ? (m_wait_d[1:0] & ~d[1:0]) : 2'b00;
    xr_s = (w && a == A_WAIT) ? (m_wait_s[1:0] & ~d[1:0] & 2'b01) : 2'b00;
    if (w && a == A_WAIT) begin m_wait_d = d; m_wait_s = d; end
    if (w && a == A_V0)   begin m_v0_d = d; m_v0_s = d; end
    if (w && a == A_V1)   m_v1_d = d;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    chk("R10", "dual rsp_valid", 32'(d_rv), 32'h1);
    chk("R10", "single rsp_valid", 32'(s_rv), 32'h1);
    chk(tag_of(1'b1, a), "dual rsp_err", 32'(d_re), 32'(!eh_d));
    chk(tag_of(1'b0, a), "single rsp_err", 32'(s_re), 32'(!eh_s));
    chk(tag_of(1'b1, a), "dual rdata", d_rd, er_d);
    chk(tag_of(1'b0, a), "single rdata", s_rd, er_s);
    chk("R2 R3 R4", "dual release", 32'(d_rel), 32'(xr_d));
    chk("R2 R3 R9", "single release", 32'(s_rel), 32'(xr_s));
    chk("R5", "dual cpu_wait", 32'(d_w), 32'(m_wait_d[1:0]));
    chk("R5 R9", "single cpu_wait", 32'(s_w), {31'h0, m_wait_s[0]});
    chk("R6", "dual vec0", d_v0, m_v0_d);
    chk("R6", "dual vec1", d_v1, m_v1_d);
    chk("R6", "single vec0", s_v0, m_v0_s);
    chk("R9", "single vec1", s_v1, 32'h0);
    @(negedge clk);
    chk("R2", "dual release one cycle", 32'(d_rel), 32'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "dual cpu_wait reset", 32'(d_w), 32'h2);
    chk("R1", "single cpu_wait reset", 32'(s_w), 32'h0);
    chk("R1", "dual vec0 reset", d_v0, 32'h1000_0000);
    chk("R1", "dual vec1 reset", d_v1, 32'h1000_0000);
    chk("R1", "single vec0 reset", s_v0, 32'h1000_0000);
    chk("R1", "release idle", 32'({d_rel, s_rel}), 32'h0);

    // full read sweep of every word offset (R1 R7 R8 R9)
    for (int i = 0; i < 1024; i++) do_acc(1'b0, 12'(i * 4), 32'h0);

    // R8: writes of all ones to every invalid offset, then readback
    for (int i = 0; i < 1024; i++) begin
      if (!hit(1'b1, 12'(i * 4))) do_acc(1'b1, 12'(i * 4), 32'hFFFF_FFFF);
    end
    do_acc(1'b1, 12'h011, 32'h0);
    do_acc(1'b0, 12'h016, 32'h0);
    do_acc(1'b0, A_WAIT, 32'h0);
    do_acc(1'b0, A_V0, 32'h0);
    do_acc(1'b0, A_V1, 32'h0);

    // R9 / R6: core 1 vector offset
    do_acc(1'b1, A_V1, 32'h2000_0400);
    do_acc(1'b0, A_V1, 32'h0);

    // R2 R3 R4 R5: every old/new pair of hold bits
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 4; n++) begin
        do_acc(1'b1, A_WAIT, {8'hA5, 8'(p * 17 + n), 14'h1234, 2'(p)});
        do_acc(1'b1, A_WAIT, {8'h5A, 8'(n * 29 + p), 14'h2ACE, 2'(n)});
        do_acc(1'b0, A_WAIT, 32'h0);
      end
    end

    // R6: vector patterns
    do_acc(1'b1, A_V0, 32'h0000_0000);
    do_acc(1'b0, A_V0, 32'h0);
    do_acc(1'b1, A_V0, 32'hFFFF_FF80);
    do_acc(1'b0, A_V0, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule